// File: doc/BRIEF.md
# Two-Pool Memory Device Power Manager

This block sets the power state of a group of memory devices, eight by default. Each device belongs to either an active pool or a nap pool. Devices in the active pool are held awake, either fully ACTIVE or in STANDBY. Devices in the nap pool are held in NAP, or in the deeper PDN state when deep sleep is selected. Software picks the size of the active pool and the number of pool members that may be fully ACTIVE at once. The members that were used most recently take the ACTIVE slots, and the remaining members drop back to STANDBY.

Accesses arrive on a valid/ready request channel that carries a device index. A request for a pool member is granted at once and moves that device to the head of the recency order. A request for a napping device brings it into the pool as the most recent member. If the pool is full, the least recently used member is evicted to the nap pool. The grant is held back until a programmable wake-up count has elapsed: the NAP count, or the PDN count in deep-sleep mode. An optional inactivity timer watches a channel-idle flag and sends the least recently used member to the nap pool after a programmed number of idle cycles. If the pool size is lowered below the current occupancy, the excess members are released one per cycle.

Back-pressure on the request channel follows the usual rules. Once `req_valid` is raised, it and `req_id` must hold until the cycle in which `req_ready` is high. The transfer completes on the clock edge that ends that cycle, and `req_ready` is never high for two cycles in a row.

Top module: `pm_two_pool_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every device reports NAP, the active pool is empty and `req_ready` is low.
- R2: The state field of device d occupies `dev_state[2d+1:2d]`. The codes are 2'b11 ACTIVE, 2'b10 STANDBY, 2'b01 NAP and 2'b00 PDN.
- R3: A request for an active-pool device raises `req_ready` in the cycle after the one in which `req_valid` first appears. The device is ACTIVE at that grant.
- R4: A request for a napping device makes it the most recent pool member and ACTIVE. `req_ready` rises W+1 cycles after the request is first seen. W is `nap_wake_cyc`, or `pdn_wake_cyc` when `deep_sleep` is high, and a programmed 0 acts as 1.
- R5: `pool_sel` values 0, 1, 2 and 3 give an active-pool capacity of 1, 2, 4 and 8 devices. A wake-up into a full pool evicts the least recently used member to the nap pool.
- R6: `limit_sel` values 0, 1, 2 and 3 allow 1, 2, 4 and 4 ACTIVE devices. The most recent members up to that limit are ACTIVE and the other members are STANDBY.
- R7: Every granted request moves its device to the most-recent position, and the relative order of the other members is kept.
- R8: With `idle_en` high, the least recently used member is demoted after `idle_thresh`+1 consecutive cycles in which `chan_idle` is high and no request is pending. The count then restarts. With `idle_en` low, or while the channel is busy, no demotion happens.
- R9: With `deep_sleep` high, nap-pool devices report PDN, and wake-ups use `pdn_wake_cyc`.
- R10: When the capacity drops below the occupancy, one least recently used member is released per cycle until the pool fits. Requests wait until then.
- R11: `req_ready` is a single-cycle pulse that is only given to a pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pool_sel | input | 2 | Active-pool capacity select |
| limit_sel | input | 2 | ACTIVE-device limit select |
| deep_sleep | input | 1 | Hold napping devices in PDN instead of NAP |
| idle_en | input | 1 | Enable inactivity demotion |
| idle_thresh | input | IDLE_W | Idle-cycle threshold |
| nap_wake_cyc | input | WAKE_W | Wake-up cycles from NAP |
| pdn_wake_cyc | input | WAKE_W | Wake-up cycles from PDN |
| chan_idle | input | 1 | Channel is idle this cycle |
| req_valid | input | 1 | Access request pending |
| req_id | input | IDW | Target device of the request |
| req_ready | output | 1 | Request granted, device awake |
| dev_state | output | 2*NDEV | Commanded power state per device |

## Verification
The assertions rely on the requester obeying the hold rule: `req_valid` stays high and `req_id` stays stable from the cycle the request appears until the grant. The bench's driver task raises a request and keeps both signals unchanged until it has seen `req_ready`, and it lowers `req_valid` only after the transferring edge. The configuration inputs are changed only while no request is outstanding. This keeps the pool-capacity and idle properties free of races with a sequencer that is still busy. `chan_idle` is held low during every access, so the inactivity counter only runs in the stretches the bench sets aside for it.

// File: rtl/pm_pool_pkg.sv
package pm_pool_pkg;

  typedef enum logic [1:0] {
    PWR_PDN  = 2'b00,
    PWR_NAP  = 2'b01,
    PWR_STBY = 2'b10,
    PWR_ACT  = 2'b11
  } pwr_state_e;

  typedef enum logic [1:0] {
    LST_NOP,
    LST_TOUCH,
    LST_INSERT,
    LST_DROP
  } lst_op_e;

  typedef enum logic [1:0] {
    FSM_IDLE,
    FSM_WAKE,
    FSM_GRANT
  } seq_state_e;

  function automatic int act_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/pm_lru_list.sv
module pm_lru_list
  import pm_pool_pkg::*;
#(
  parameter int NDEV = 8,
  parameter int IDW  = 3,
  parameter int CW   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  lst_op_e                   op,
  input  logic [IDW-1:0]            op_id,
  input  logic [CW-1:0]             cap,
  output logic [CW-1:0]             occ,
  output logic                      hit,
  output logic [NDEV-1:0]           present,
  output logic [NDEV-1:0][IDW-1:0]  rank
);

  // slot[0] is the most recent member, slot[occ-1] the least recent
  logic [NDEV-1:0][IDW-1:0] slot;
  logic [IDW-1:0]           hit_pos;

  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    for (int i = 0; i < NDEV; i++) begin
      if (CW'(i) < occ && slot[i] == op_id) begin
        hit     = 1'b1;
        hit_pos = IDW'(i);
      end
    end
  end

  always_comb begin
    present = '0;
    rank    = '0;
    for (int d = 0; d < NDEV; d++) begin
      for (int i = 0; i < NDEV; i++) begin
        if (CW'(i) < occ && slot[i] == IDW'(d)) begin
          present[d] = 1'b1;
          rank[d]    = IDW'(i);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      occ  <= '0;
    end else begin
      case (op)
        LST_TOUCH: begin
          if (hit) begin
            for (int i = 1; i < NDEV; i++) begin
              if (IDW'(i) <= hit_pos) slot[i] <= slot[i-1];
            end
            slot[0] <= op_id;
          end
        end
        LST_INSERT: begin
          for (int i = 1; i < NDEV; i++) slot[i] <= slot[i-1];
          slot[0] <= op_id;
          if (occ < cap) occ <= occ + CW'(1);
        end
        LST_DROP: begin
          if (occ != '0) occ <= occ - CW'(1);
        end
        default: ;
      endcase
    end
  end

  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(NDEV));

  // R7
  unique_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(present) == int'(occ));

endmodule

// File: rtl/pm_wake_timer.sv
module pm_wake_timer #(
  parameter int WAKE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAKE_W-1:0] cycles,
  output logic              done
);

  logic [WAKE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (cycles == '0) ? WAKE_W'(1) : cycles;
    end else if (cnt != '0) begin
      cnt <= cnt - WAKE_W'(1);
    end
  end

  assign done = (cnt == WAKE_W'(1));

endmodule

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qualify,
  input  logic [IDLE_W-1:0] thresh,
  output logic              fire
);

  logic [IDLE_W-1:0] cnt;

  assign fire = qualify && (cnt == thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!qualify || fire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + IDLE_W'(1);
    end
  end

endmodule

// File: rtl/pm_two_pool_ctrl.sv
module pm_two_pool_ctrl
  import pm_pool_pkg::*;
#(
  parameter int NDEV   = 8,
  parameter int WAKE_W = 16,
  parameter int IDLE_W = 16,
  localparam int IDW   = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int CW    = $clog2(NDEV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pool_sel,
  input  logic [1:0]        limit_sel,
  input  logic              deep_sleep,
  input  logic              idle_en,
  input  logic [IDLE_W-1:0] idle_thresh,
  input  logic [WAKE_W-1:0] nap_wake_cyc,
  input  logic [WAKE_W-1:0] pdn_wake_cyc,
  input  logic              chan_idle,
  input  logic              req_valid,
  input  logic [IDW-1:0]    req_id,
  output logic              req_ready,
  output logic [2*NDEV-1:0] dev_state
);

  seq_state_e               state, state_nxt;
  lst_op_e                  op;
  logic [CW-1:0]            cap, lim, occ;
  logic                     hit, shrink, wake_load, wake_done;
  logic                     idle_qual, idle_fire;
  logic [NDEV-1:0]          present, act_vec;
  logic [NDEV-1:0][IDW-1:0] rank;

  always_comb begin
    int c;
    c = 1 << pool_sel;
    if (c > NDEV) c = NDEV;
    cap = CW'(c);
  end

  always_comb begin
    int l;
    l = act_limit(limit_sel);
    if (l > NDEV) l = NDEV;
    lim = CW'(l);
  end

  assign shrink = (occ > cap);

  pm_lru_list #(.NDEV(NDEV), .IDW(IDW), .CW(CW)) u_list (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .op_id   (req_id),
    .cap     (cap),
    .occ     (occ),
    .hit     (hit),
    .present (present),
    .rank    (rank)
  );

  pm_wake_timer #(.WAKE_W(WAKE_W)) u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (wake_load),
    .cycles (deep_sleep ? pdn_wake_cyc : nap_wake_cyc),
    .done   (wake_done)
  );

  assign idle_qual = idle_en && chan_idle && (state == FSM_IDLE) &&
                     !req_valid && !shrink && (occ != '0);

  pm_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .qualify (idle_qual),
    .thresh  (idle_thresh),
    .fire    (idle_fire)
  );

  // request sequencer: shrink first, then requests, then idle demotion
  always_comb begin
    op        = LST_NOP;
    wake_load = 1'b0;
    state_nxt = state;
    case (state)
      FSM_IDLE: begin
        if (shrink) begin
          op = LST_DROP;
        end else if (req_valid) begin
          if (hit) begin
            op        = LST_TOUCH;
            state_nxt = FSM_GRANT;
          end else begin
            op        = LST_INSERT;
            wake_load = 1'b1;
            state_nxt = FSM_WAKE;
          end
        end else if (idle_fire) begin
          op = LST_DROP;
        end
      end
      FSM_WAKE:  if (wake_done) state_nxt = FSM_GRANT;
      FSM_GRANT: state_nxt = FSM_IDLE;
      default:   state_nxt = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= FSM_IDLE;
    else        state <= state_nxt;
  end

  assign req_ready = (state == FSM_GRANT);

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    pwr_state_e ps;
    always_comb begin
      if (present[d]) ps = (CW'(rank[d]) < lim) ? PWR_ACT : PWR_STBY;
      else            ps = deep_sleep ? PWR_PDN : PWR_NAP;
    end
    assign dev_state[2*d +: 2] = ps;
    assign act_vec[d]          = (ps == PWR_ACT);
  end

  // R11
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R11
  ready_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  // R6
  active_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_vec) <= int'(lim));

  // R3
  grant_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> act_vec[req_id]);

  // R5
  pool_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pool_sel) && $past(occ <= cap)) |-> (occ <= cap));

  // R8
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FSM_IDLE && !req_valid && !shrink && !chan_idle) |=> (occ == $past(occ)));

endmodule

// File: tb/sim_pm_two_pool_ctrl.sv
module sim_pm_two_pool_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 8;
  localparam int WW = 16;
  localparam int IW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pool_sel = 2'd2, limit_sel = 2'd1;
  logic deep_sleep = 1'b0, idle_en = 1'b0, chan_idle = 1'b0;
  logic [IW-1:0] idle_thresh = '0;
  logic [WW-1:0] nap_wake_cyc = 16'd3, pdn_wake_cyc = 16'd20;
  logic req_valid = 1'b0;
  logic [2:0] req_id = '0;
  logic req_ready;
  logic [2*NDEV-1:0] dev_state;

  pm_two_pool_ctrl #(.NDEV(NDEV), .WAKE_W(WW), .IDLE_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .pool_sel(pool_sel), .limit_sel(limit_sel),
    .deep_sleep(deep_sleep), .idle_en(idle_en), .idle_thresh(idle_thresh),
    .nap_wake_cyc(nap_wake_cyc), .pdn_wake_cyc(pdn_wake_cyc),
    .chan_idle(chan_idle), .req_valid(req_valid), .req_id(req_id),
    .req_ready(req_ready), .dev_state(dev_state));

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int exp_lat[$];
  string exp_req[$];
  int model[$];
  int cap_m = 4, lim_m = 2;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_code(input int d);
    for (int i = 0; i < model.size(); i++)
      if (model[i] == d) return (i < lim_m) ? 3 : 2;
    return deep_sleep ? 0 : 1;
  endfunction

  task automatic check_states(input string req);
    for (int d = 0; d < NDEV; d++)
      check(int'(dev_state[2*d +: 2]) == exp_code(d), req,
            $sformatf("state dev%0d", d), int'(dev_state[2*d +: 2]), exp_code(d));
  endtask

  function automatic bit model_access(input int id);
    for (int i = 0; i < model.size(); i++) begin
      if (model[i] == id) begin
        model.delete(i);
        model.push_front(id);
        return 1;
      end
    end
    model.push_front(id);
    if (model.size() > cap_m) void'(model.pop_back());
    return 0;
  endfunction

  // driver: pushes the expected grant latency, then runs the handshake
  task automatic access(input int id, input string req);
    bit h;
    int w;
    w = deep_sleep ? int'(pdn_wake_cyc) : int'(nap_wake_cyc);
    if (w == 0) w = 1;
    h = model_access(id);
    exp_lat.push_back(h ? 2 : w + 2);
    exp_req.push_back(req);
    @(negedge clk);
    req_valid = 1'b1;
    req_id = 3'(id);
    do begin @(posedge clk); #1; end while (!req_ready);
    @(posedge clk); #1;
    check(req_ready == 1'b0, "R11", "ready after transfer", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    check_states(req);
  endtask

  // monitor: measures grant latency and compares with the queue
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk); #2;
      if (req_valid) begin
        lat++;
        if (req_ready) begin
          if (exp_lat.size() == 0) check(0, "R11", "unexpected grant", lat, 0);
          else check(lat == exp_lat.pop_front(), exp_req.pop_front(), "grant latency",
                     lat, lat);
          lat = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 and R2: reset state, NAP code 01 in every field
    check(req_ready == 1'b0, "R1", "ready in reset", int'(req_ready), 0);
    check_states("R1");
    check(dev_state == {NDEV{2'b01}}, "R2", "nap encoding", int'(dev_state), 16'h5555);
    rst_n = 1'b1;
    @(negedge clk);
    check_states("R1");

    // R4: misses fill the pool; R6: two most recent ACTIVE
    access(0, "R4");
    access(1, "R4");
    access(2, "R6");
    access(3, "R6");
    // R3 and R7: hits reorder
    access(0, "R3");
    access(1, "R7");
    // R5: full pool evicts least recent (device 2)
    access(5, "R5");
    // R4: zero wake count acts as one
    nap_wake_cyc = 16'd0;
    access(6, "R4");
    nap_wake_cyc = 16'd3;

    // R6: limit select changes
    @(negedge clk); limit_sel = 2'd0; lim_m = 1; #1; check_states("R6");
    @(negedge clk); limit_sel = 2'd3; lim_m = 4; #1; check_states("R6");
    @(negedge clk); limit_sel = 2'd1; lim_m = 2; #1; check_states("R6");

    // R8: idle monitoring disabled has no effect
    @(negedge clk); chan_idle = 1'b1; idle_en = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk); check_states("R8");
    // R8: threshold 4 -> demotion on the 5th idle cycle
    idle_thresh = 16'd4; idle_en = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); check_states("R8");
    @(posedge clk);
    @(negedge clk);
    void'(model.pop_back());
    check_states("R8");
    chan_idle = 1'b0; idle_en = 1'b0;

    // R10: capacity falls to 1, one release per cycle
    pool_sel = 2'd0; cap_m = 1;
    @(posedge clk); @(negedge clk);
    void'(model.pop_back());
    check_states("R10");
    @(posedge clk); @(negedge clk);
    void'(model.pop_back());
    check_states("R10");
    pool_sel = 2'd3; cap_m = 8;
    access(7, "R5");
    access(6, "R3");

    // R9: deep sleep shows PDN and uses the long wake count
    @(negedge clk); deep_sleep = 1'b1; #1; check_states("R9");
    access(4, "R9");
    @(negedge clk); deep_sleep = 1'b0; #1; check_states("R9");

    repeat (4) @(posedge clk);
    #1;
    check(exp_lat.size() == 0, "R11", "grants outstanding", exp_lat.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule